// File: doc/BRIEF.md
# Locked 64-bit Compare-and-Exchange Sequencer

This block performs one atomic compare-and-exchange on a 64-bit memory word over a simple single-port bus. A requester presents an address, a comparand given as a high and a low 32-bit half, a replacement value given the same way, and a choice of whether the bus lock is used. The sequencer reads the word at the address and compares all 64 bits with `{cmp_hi, cmp_lo}`. It then writes the word back: the replacement `{new_hi, new_lo}` on a match, or the unchanged word it read on a mismatch. At the end it reports a success flag and the word it observed.

There is always exactly one read followed by exactly one write, whatever the comparison gives. When locking is requested, the bus lock covers the whole read-to-write span, including the compare cycle between the two accesses. That way, no other master can slip an access between them. Each bus access holds its strobe and address until the memory answers with ready. A one-cycle completion pulse marks when the result outputs are valid.

Top module: `cas64_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `req_ready` is 1. `bus_rd`, `bus_wr`, `bus_lock`, `done` and `swapped` are 0, and `obs_hi`/`obs_lo` are 0.
- R2: The comparand is `{cmp_hi, cmp_lo}` (high half in bits 63:32) and is compared with all 64 bits read. `swapped` becomes 1 when they are equal and 0 when any bit differs.
- R3: On a match, the single write carries `{new_hi, new_lo}` to the requested address.
- R4: On a mismatch, the single write carries back the unchanged word that was read. On a mismatch and on a match alike, `{obs_hi, obs_lo}` equals the word read.
- R5: Every accepted request produces exactly one accepted read cycle and then exactly one accepted write cycle.
- R6: With `req_lock` = 1 at acceptance, `bus_lock` is 1 in every cycle from the first read-strobe cycle through the cycle in which the write's ready is sampled, including the cycle between read and write. It is 0 from the next cycle on.
- R7: With `req_lock` = 0 at acceptance, `bus_lock` stays 0 for the whole operation.
- R8: `bus_rd` and `bus_wr` are never 1 together. Once a strobe is raised, the strobe and `bus_addr` stay unchanged until a cycle with `bus_ready` = 1.
- R9: A request is taken only in a cycle with `req_valid` = 1 and `req_ready` = 1. `req_ready` is 0 from acceptance until the operation ends, and request inputs that change while busy have no effect on that operation.
- R10: `done` is a single-cycle pulse that rises 2L+4 cycles after the accepting cycle's clock edge is approached, where L is the number of wait cycles each bus access sees. `swapped` and `obs_*` keep their values after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_lock | input | 1 | Use the bus lock for this operation |
| req_addr | input | AW | Target word address |
| cmp_hi | input | HW | Comparand high half |
| cmp_lo | input | HW | Comparand low half |
| new_hi | input | HW | Replacement high half |
| new_lo | input | HW | Replacement low half |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| swapped | output | 1 | Last operation matched and stored the replacement |
| obs_hi | output | HW | High half of the word observed by the last operation |
| obs_lo | output | HW | Low half of the word observed by the last operation |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 2*HW | Write data |
| bus_rdata | input | 2*HW | Read data, valid with ready during a read |
| bus_ready | input | 1 | Access completes at this clock edge |
| bus_lock | output | 1 | Bus lock |

## Verification
With L wait cycles per access, the read takes L+1 cycles and the compare takes one. The write takes another L+1, so `done` and the result outputs appear 2L+4 cycles after the request is presented. The bench counts falling edges from the request to the pulse and compares the count with 2L+4. It samples `swapped` and `obs_*` in the pulse cycle, and checks one cycle later that the pulse has ended and the results are held. Every bus cycle is checked at the falling edge that precedes its accepting rising edge, with the ready value about to be sampled. This gives exact timing for read and write counts, the written address and data, the lock level and strobe stability.

// File: rtl/cas64_pkg.sv
package cas64_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CMP   = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } cas_state_e;

endpackage

// File: rtl/cas64_fsm.sv
module cas64_fsm
  import cas64_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bus_ready,
  output cas_state_e state,
  output logic       take,
  output logic       rd_accept,
  output logic       cmp_step,
  output logic       wr_accept
);

  cas_state_e state_q, state_d;

  assign state     = state_q;
  assign take      = (state_q == ST_IDLE)  && start;
  assign rd_accept = (state_q == ST_READ)  && bus_ready;
  assign cmp_step  = (state_q == ST_CMP);
  assign wr_accept = (state_q == ST_WRITE) && bus_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)     state_d = ST_READ;
      ST_READ:  if (bus_ready) state_d = ST_CMP;
      ST_CMP:                  state_d = ST_WRITE;
      ST_WRITE: if (bus_ready) state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/cas64_cmp.sv
module cas64_cmp #(
  parameter int HW = 32
) (
  input  logic [HW-1:0]   cmp_hi,
  input  logic [HW-1:0]   cmp_lo,
  input  logic [HW-1:0]   new_hi,
  input  logic [HW-1:0]   new_lo,
  input  logic [2*HW-1:0] seen,
  output logic            hit,
  output logic [2*HW-1:0] wr_word
);

  localparam int DW = 2 * HW;

  function automatic logic [DW-1:0] join_word(input logic [HW-1:0] hi,
                                              input logic [HW-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic words_match(input logic [DW-1:0] a,
                                       input logic [DW-1:0] b);
    return ~|(a ^ b);
  endfunction

  function automatic logic [DW-1:0] pick_store(input logic            m,
                                               input logic [DW-1:0] fresh,
                                               input logic [DW-1:0] old);
    return m ? fresh : old;
  endfunction

  logic [DW-1:0] cmp_word;
  logic [DW-1:0] rep_word;

  assign cmp_word = join_word(cmp_hi, cmp_lo);
  assign rep_word = join_word(new_hi, new_lo);
  assign hit      = words_match(cmp_word, seen);
  assign wr_word  = pick_store(hit, rep_word, seen);

endmodule

// File: rtl/cas64_seq.sv
module cas64_seq
  import cas64_pkg::*;
#(
  parameter int AW = 8,
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_lock,
  input  logic [AW-1:0]   req_addr,
  input  logic [HW-1:0]   cmp_hi,
  input  logic [HW-1:0]   cmp_lo,
  input  logic [HW-1:0]   new_hi,
  input  logic [HW-1:0]   new_lo,
  output logic            req_ready,
  output logic            done,
  output logic            swapped,
  output logic [HW-1:0]   obs_hi,
  output logic [HW-1:0]   obs_lo,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [AW-1:0]   bus_addr,
  output logic [2*HW-1:0] bus_wdata,
  input  logic [2*HW-1:0] bus_rdata,
  input  logic            bus_ready,
  output logic            bus_lock
);

  localparam int DW = 2 * HW;

  cas_state_e    state;
  logic          take, rd_accept, cmp_step, wr_accept;
  logic          hit, in_span;
  logic [DW-1:0] wr_word;

  logic [AW-1:0] addr_q;
  logic [HW-1:0] chi_q, clo_q, nhi_q, nlo_q;
  logic          lock_q;
  logic [DW-1:0] seen_q, wdat_q, obs_q;
  logic          hit_q, swapped_q;

  cas64_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (req_valid),
    .bus_ready (bus_ready),
    .state     (state),
    .take      (take),
    .rd_accept (rd_accept),
    .cmp_step  (cmp_step),
    .wr_accept (wr_accept)
  );

  cas64_cmp #(.HW(HW)) u_cmp (
    .cmp_hi  (chi_q),
    .cmp_lo  (clo_q),
    .new_hi  (nhi_q),
    .new_lo  (nlo_q),
    .seen    (seen_q),
    .hit     (hit),
    .wr_word (wr_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      chi_q     <= '0;
      clo_q     <= '0;
      nhi_q     <= '0;
      nlo_q     <= '0;
      lock_q    <= 1'b0;
      seen_q    <= '0;
      wdat_q    <= '0;
      hit_q     <= 1'b0;
      swapped_q <= 1'b0;
      obs_q     <= '0;
    end else begin
      if (take) begin
        addr_q <= req_addr;
        chi_q  <= cmp_hi;
        clo_q  <= cmp_lo;
        nhi_q  <= new_hi;
        nlo_q  <= new_lo;
        lock_q <= req_lock;
      end
      if (rd_accept) seen_q <= bus_rdata;
      if (cmp_step) begin
        hit_q  <= hit;
        wdat_q <= wr_word;
      end
      if (wr_accept) begin
        swapped_q <= hit_q;
        obs_q     <= seen_q;
      end
    end
  end

  assign in_span   = (state == ST_READ) || (state == ST_CMP) || (state == ST_WRITE);
  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign bus_rd    = (state == ST_READ);
  assign bus_wr    = (state == ST_WRITE);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdat_q;
  assign bus_lock  = lock_q && in_span;
  assign swapped   = swapped_q;
  assign obs_hi    = obs_q[DW-1:HW];
  assign obs_lo    = obs_q[HW-1:0];

endmodule

// File: rtl/cas64_seq_chk.sv
module cas64_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_lock,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          done,
  input logic          req_ready,
  input logic          lock_q,
  input logic          rd_accept,
  input logic          wr_accept
);

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr))); // R8

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr))); // R8

  AST_RD_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> (!bus_rd && !bus_wr && !done)); // R5

  AST_LOCK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && !wr_accept) |=> bus_lock); // R6

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (!bus_lock && done)); // R6

  AST_NO_LOCK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |-> !bus_lock); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_rd && !bus_wr && !bus_lock && !done)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

bind cas64_seq cas64_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_lock  (bus_lock),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .done      (done),
  .req_ready (req_ready),
  .lock_q    (lock_q),
  .rd_accept (rd_accept),
  .wr_accept (wr_accept)
);

// File: tb/cas64_seq_test.sv
`timescale 1ns/1ps
module cas64_seq_test;
  localparam int AW = 8;
  localparam int HW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_lock = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [HW-1:0] cmp_hi = '0, cmp_lo = '0, new_hi = '0, new_lo = '0;
  logic          req_ready, done, swapped, bus_rd, bus_wr, bus_lock;
  logic [HW-1:0] obs_hi, obs_lo;
  logic [AW-1:0] bus_addr;
  logic [63:0]   bus_wdata;
  logic [63:0]   bus_rdata;
  logic          bus_ready;

  cas64_seq #(.AW(AW), .HW(HW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lock(req_lock),
    .req_addr(req_addr), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .new_hi(new_hi),
    .new_lo(new_lo), .req_ready(req_ready), .done(done), .swapped(swapped),
    .obs_hi(obs_hi), .obs_lo(obs_lo), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_lock(bus_lock)
  );

  int total = 0;
  int bad = 0;

  function automatic logic [63:0] seed_word(input int i);
    logic [31:0] hi, lo;
    hi = 32'h5A00_0000 + 32'(i) * 32'h0101;
    lo = 32'hC300_0000 ^ (32'(i) * 32'h1111);
    return {hi, lo};
  endfunction

  // bus memory model and protocol monitor, all at the falling edge
  logic [63:0]   mem [16];
  int            lat_cfg = 0, wcnt = 0;
  int            rd_cnt = 0, wr_cnt = 0, lock_err = 0, hs_err = 0;
  logic [AW-1:0] last_waddr = '0;
  logic [63:0]   last_wdata = '0;
  logic          cur_lk = 1'b0;
  logic          in_win = 1'b0;
  logic          prev_pend = 1'b0, prev_rd = 1'b0, prev_wr = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) begin : bus_model
    logic rdy;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] = seed_word(i);
      bus_ready = 1'b0;
      bus_rdata = '0;
      wcnt = 0;
      in_win = 1'b0;
      prev_pend = 1'b0;
    end else begin
      rdy = 1'b0;
      if (bus_ready) wcnt = 0;
      else if (bus_rd || bus_wr) begin
        if (wcnt >= lat_cfg) rdy = 1'b1;
        else wcnt++;
      end
      if (bus_rd && bus_wr) hs_err++;
      if (prev_pend && (bus_rd !== prev_rd || bus_wr !== prev_wr || bus_addr !== prev_addr))
        hs_err++;
      if (bus_rd || bus_wr || in_win) begin
        if (bus_lock !== cur_lk) lock_err++;
      end else if (bus_lock !== 1'b0) lock_err++;
      if (rdy && bus_rd) begin
        bus_rdata = mem[bus_addr[3:0]];
        rd_cnt++;
        in_win = 1'b1;
      end
      if (rdy && bus_wr) begin
        mem[bus_addr[3:0]] = bus_wdata;
        wr_cnt++;
        last_waddr = bus_addr;
        last_wdata = bus_wdata;
        in_win = 1'b0;
      end
      prev_pend = (bus_rd || bus_wr) && !rdy;
      prev_rd   = bus_rd;
      prev_wr   = bus_wr;
      prev_addr = bus_addr;
      bus_ready = rdy;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] shadow [16];

  task automatic run_op(input int a, input int kind, input bit lk, input int lat);
    logic [63:0] base, cw, nw, expw;
    bit          match, busy_ok, seen_done;
    int          cyc, rd0, wr0, le0, he0;
    base = shadow[a];
    cw = base;
    if (kind == 1) cw[63:32] = cw[63:32] ^ 32'h0000_0001;
    if (kind == 2) cw[31:0]  = cw[31:0]  ^ 32'h8000_0000;
    if (kind == 3) cw = ~cw;
    nw = {~base[63:32] + 32'(lat), base[31:0] + 32'h77 + 32'(a)};
    match = (cw == base);
    expw = match ? nw : base;

    @(negedge clk); #1;
    rd0 = rd_cnt; wr0 = wr_cnt; le0 = lock_err; he0 = hs_err;
    lat_cfg = lat;
    cur_lk = lk;
    req_addr = AW'(a);
    cmp_hi = cw[63:32]; cmp_lo = cw[31:0];
    new_hi = nw[63:32]; new_lo = nw[31:0];
    req_lock = lk;
    req_valid = 1'b1;
    cyc = 0; busy_ok = 1'b1; seen_done = 1'b0;
    while (cyc < 200 && !seen_done) begin
      @(negedge clk); #1;
      cyc++;
      if (cyc == 1) begin
        // R9: inputs changed while busy must have no effect
        req_addr = AW'(a ^ 5);
        cmp_hi = ~cmp_hi; cmp_lo = ~cmp_lo;
        new_hi = new_hi ^ 32'hFFFF_0000; new_lo = ~new_lo;
        req_lock = ~lk;
      end
      if (done) seen_done = 1'b1;
      else if (req_ready) busy_ok = 1'b0;
    end
    req_valid = 1'b0;
    chk(cyc == 2 * lat + 4, "R10 done latency", 64'(cyc), 64'(2 * lat + 4));
    chk(swapped == match, "R2 swapped flag", 64'(swapped), 64'(match));
    chk({obs_hi, obs_lo} == base, "R4 observed word", {obs_hi, obs_lo}, base);
    chk(busy_ok, "R9 req_ready low while busy", 64'(busy_ok), 64'd1);
    @(negedge clk); #1;
    chk(done == 1'b0, "R10 done single pulse", 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R9 idle after done", 64'(req_ready), 64'd1);
    chk(swapped == match && {obs_hi, obs_lo} == base, "R10 results held",
        {obs_hi, obs_lo}, base);
    chk(rd_cnt - rd0 == 1, "R5 one read", 64'(rd_cnt - rd0), 64'd1);
    chk(wr_cnt - wr0 == 1, "R5 one write", 64'(wr_cnt - wr0), 64'd1);
    chk(last_waddr == AW'(a), "R9 write address", 64'(last_waddr), 64'(a));
    if (match) chk(last_wdata == expw, "R3 replacement written", last_wdata, expw);
    else       chk(last_wdata == expw, "R4 old word written back", last_wdata, expw);
    if (lk) chk(lock_err == le0, "R6 lock span", 64'(lock_err - le0), 64'd0);
    else    chk(lock_err == le0, "R7 no lock", 64'(lock_err - le0), 64'd0);
    chk(hs_err == he0, "R8 strobe handshake", 64'(hs_err - he0), 64'd0);
    shadow[a] = expw;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) shadow[i] = seed_word(i);
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && !bus_rd && !bus_wr && !bus_lock && !done,
        "R1 control outputs in reset",
        {59'd0, req_ready, bus_rd, bus_wr, bus_lock, done}, 64'h10);
    chk(!swapped && {obs_hi, obs_lo} == 64'd0, "R1 results in reset",
        {obs_hi, obs_lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready && !bus_rd && !bus_wr && !bus_lock && !done && !swapped,
        "R1 state after reset",
        {58'd0, swapped, req_ready, bus_rd, bus_wr, bus_lock, done}, 64'h10);
    for (int lat = 0; lat < 4; lat++)
      for (int kind = 0; kind < 4; kind++)
        for (int lk = 0; lk < 2; lk++)
          run_op((lat * 8 + kind * 2 + lk) % 16, kind, lk[0], lat);
    @(negedge clk); #1;
    for (int i = 0; i < 16; i++)
      chk(mem[i] == shadow[i], "R3 R4 final memory image", mem[i], shadow[i]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule